// File: doc/BRIEF.md
# TAP Controller for Boundary-Scan Access

This block is the state-keeping core of a test access port in the IEEE 1149.1 style. It follows the test-mode select line on every rising edge of the test clock through the standard sixteen-state machine. It holds a 4-bit instruction, and it shifts serial data from the test data input to the test data output through whichever register the active instruction selects. The block has two such registers: a one-bit bypass stage and a 32-bit device identification register.

The test data output is driven only while the machine is in one of the two shift states. The enable is brought out as a separate signal so that a pad or a shared-port multiplexer can tri-state the line. A decoded ownership signal tells the chip-level port arbiter whether the loaded instruction belongs to this controller. Other controllers on the same pins can then take over when this one is parked in bypass.

Top module: `tap_ctrl`

## Requirements
- R1: While `rst_n` is low, the machine sits in Test-Logic-Reset, `tdo_en` and `tdo` are 0, and the identification instruction (code 0010) is active with `port_owned` high. This holds whatever `tms` does, and it also holds when reset is asserted in the middle of a scan.
- R2: The state advances on each rising `tck` edge according to the `tms` value sampled on that edge. It follows the standard sixteen-state graph, including the Exit1, Pause and Exit2 detours of both the data and the instruction branch.
- R3: Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state. Entering that state makes the identification instruction active again.
- R4: Serial data moves from `tdi` toward `tdo` least significant bit first. `tdo` changes only on the falling edge of `tck`.
- R5: `tdo_en` is high exactly while the machine is in Shift-IR or Shift-DR, updated on the falling edge. Outside those states `tdo` is 0.
- R6: Capture-IR loads the pattern 0001 into the instruction shift stage, so the first bits shifted out of an instruction scan read 1, 0, 0, 0.
- R7: A shifted instruction takes effect on the falling `tck` edge in Update-IR and not before.
- R8: With code 0010 active, Capture-DR loads the 32-bit `ID_VALUE` (default 32'h4A5C_3E97, bit 0 set), and a 32-bit scan returns it unchanged.
- R9: Code 1111 and every code other than 0010 select the bypass stage. Capture-DR clears that stage, so a scan returns a 0 first and then the `tdi` bits delayed by one stage.
- R10: `port_owned` is 1 while code 0010 is active and 0 while a bypass-selecting code is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a rising `tck` edge |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, changes on falling `tck` |
| tdo_en | output | 1 | Output enable for `tdo`, high in the shift states |
| port_owned | output | 1 | Active instruction claims the shared port |

## Verification
The bench attacks the edge-timing corners. If a design updated the instruction on the rising edge, or presented `tdo` one edge early, a scan would return a shifted or rotated identification word, and a bypass scan would lose its leading 0. The bench takes the data branch through Pause and Exit2 in the middle of a scan, and it uses five-ones escapes from random states after loading bypass. A wrong transition in either path would corrupt the rejoined data or leave ownership low. Undefined codes and a reset asserted in the middle of a shift catch a decoder that treats unknown codes as owned, and a reset that fails to clear the output enable at once.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;

  typedef enum logic [3:0] {
    S_RESET, S_IDLE,
    S_SEL_DR, S_CAP_DR, S_SHF_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SHF_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_e;

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_RESET:  state_d = tms ? S_RESET  : S_IDLE;
      S_IDLE:   state_d = tms ? S_SEL_DR : S_IDLE;
      S_SEL_DR: state_d = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: state_d = tms ? S_EX1_DR : S_SHF_DR;
      S_SHF_DR: state_d = tms ? S_EX1_DR : S_SHF_DR;
      S_EX1_DR: state_d = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: state_d = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: state_d = tms ? S_UPD_DR : S_SHF_DR;
      S_UPD_DR: state_d = tms ? S_SEL_DR : S_IDLE;
      S_SEL_IR: state_d = tms ? S_RESET  : S_CAP_IR;
      S_CAP_IR: state_d = tms ? S_EX1_IR : S_SHF_IR;
      S_SHF_IR: state_d = tms ? S_EX1_IR : S_SHF_IR;
      S_EX1_IR: state_d = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: state_d = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: state_d = tms ? S_UPD_IR : S_SHF_IR;
      S_UPD_IR: state_d = tms ? S_SEL_DR : S_IDLE;
      default:  state_d = S_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state_q <= S_RESET;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // Run of consecutive tms-high edges, saturating at five
  logic [2:0] ones_q;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)               ones_q <= 3'd0;
    else if (!tms)            ones_q <= 3'd0;
    else if (ones_q != 3'd5)  ones_q <= ones_q + 3'd1;
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!rst_n)
    ones_q == 3'd5 |-> state_q == S_RESET) else $error("five ones did not reach reset"); // R3
  AST_RESET_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
    (state_q == S_RESET && tms) |=> state_q == S_RESET) else $error("reset state left with tms high"); // R2

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
  import tap_pkg::*;
#(
  parameter int              IR_W      = 4,
  parameter logic [IR_W-1:0] OP_IDCODE = 4'b0010
) (
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir,
  output logic            sh_lsb
);

  localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-1){1'b0}}, 1'b1};

  logic [IR_W-1:0] sh_q, sh_d, ir_q, ir_d;
  logic            sh_en, ir_en;

  always_comb begin
    sh_en = (state == S_CAP_IR) || (state == S_SHF_IR);
    sh_d  = (state == S_CAP_IR) ? CAP_PAT : {tdi, sh_q[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  // Active instruction changes on the falling edge
  always_comb begin
    ir_en = (state == S_UPD_IR) || (state == S_RESET);
    ir_d  = (state == S_RESET) ? OP_IDCODE : sh_q;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)     ir_q <= OP_IDCODE;
    else if (ir_en) ir_q <= ir_d;
  end

  assign ir     = ir_q;
  assign sh_lsb = sh_q[0];

  AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
    state == S_CAP_IR |=> sh_q == CAP_PAT) else $error("capture pattern wrong"); // R6
  AST_IR_SHIFT_IN: assert property (@(posedge tck) disable iff (!rst_n)
    state == S_SHF_IR |=> sh_q[IR_W-1] == $past(tdi)) else $error("ir shift-in wrong"); // R4

endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
  import tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h4A5C_3E97
) (
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tdi,
  input  tap_state_e state,
  input  logic       sel_id,
  output logic       dr_lsb
);

  logic [ID_W-1:0] id_q, id_d;
  logic            byp_q, byp_d;
  logic            dr_en;

  always_comb begin
    dr_en = (state == S_CAP_DR) || (state == S_SHF_DR);
    if (state == S_CAP_DR) begin
      id_d  = ID_VALUE;
      byp_d = 1'b0;
    end else begin
      id_d  = {tdi, id_q[ID_W-1:1]};
      byp_d = tdi;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= '0;
      byp_q <= 1'b0;
    end else if (dr_en) begin
      id_q  <= id_d;
      byp_q <= byp_d;
    end
  end

  assign dr_lsb = sel_id ? id_q[0] : byp_q;

  AST_BYPASS_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
    state == S_CAP_DR |=> byp_q == 1'b0) else $error("bypass capture not zero"); // R9
  AST_ID_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
    state == S_CAP_DR |=> id_q == ID_VALUE) else $error("id capture wrong"); // R8

endmodule

// File: rtl/tap_ctrl.sv
`timescale 1ns/1ps
module tap_ctrl
  import tap_pkg::*;
#(
  parameter int              IR_W      = 4,
  parameter int              ID_W      = 32,
  parameter logic [IR_W-1:0] OP_IDCODE = 4'b0010,
  parameter logic [ID_W-1:0] ID_VALUE  = 32'h4A5C_3E97
) (
  input  logic tck,
  input  logic rst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_en,
  output logic port_owned
);

  // Reset asserts at once, releases on a rising tck edge
  logic [1:0] rsync_q;
  logic       rst_sync_n;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  tap_state_e      state;
  logic [IR_W-1:0] ir;
  logic            ir_lsb, dr_lsb, sel_id;

  tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_sync_n),
    .tms   (tms),
    .state (state)
  );

  tap_ir #(.IR_W(IR_W), .OP_IDCODE(OP_IDCODE)) u_ir (
    .tck    (tck),
    .rst_n  (rst_sync_n),
    .tdi    (tdi),
    .state  (state),
    .ir     (ir),
    .sh_lsb (ir_lsb)
  );

  assign sel_id = (ir == OP_IDCODE);

  tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck    (tck),
    .rst_n  (rst_sync_n),
    .tdi    (tdi),
    .state  (state),
    .sel_id (sel_id),
    .dr_lsb (dr_lsb)
  );

  logic tdo_d, en_d, tdo_q, en_q;
  always_comb begin
    en_d  = (state == S_SHF_IR) || (state == S_SHF_DR);
    tdo_d = (state == S_SHF_IR) ? ir_lsb :
            (state == S_SHF_DR) ? dr_lsb : 1'b0;
  end

  always_ff @(negedge tck or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tdo_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      tdo_q <= tdo_d;
      en_q  <= en_d;
    end
  end

  assign tdo        = tdo_q;
  assign tdo_en     = en_q;
  assign port_owned = sel_id;

  AST_TDO_EN_SHIFT: assert property (@(posedge tck) disable iff (!rst_sync_n)
    en_q == ((state == S_SHF_IR) || (state == S_SHF_DR))) else $error("tdo_en off its states"); // R5
  AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!rst_sync_n)
    !en_q |-> !tdo_q) else $error("tdo active while disabled"); // R5

endmodule

// File: tb/tap_ctrl_bench.sv
`timescale 1ns/1ps
module tap_ctrl_bench;

  localparam logic [31:0] IDV    = 32'h4A5C_3E97;
  localparam logic [3:0]  C_ID   = 4'b0010;
  localparam logic [3:0]  C_BYP  = 4'b1111;

  logic tck = 1'b0;
  logic rst_n, tms, tdi;
  logic tdo, tdo_en, port_owned;

  always #2.5 tck = ~tck;

  tap_ctrl u_tap_ctrl (
    .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_en(tdo_en), .port_owned(port_owned)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // Bench reference model; numbering 0 TLR,1 RTI,2..8 DR branch,9..15 IR branch
  int          m_st;
  logic [3:0]  m_irs, m_ir;
  logic        m_byp, m_tdo, m_en;
  logic [31:0] m_id;

  function automatic int nx(int s, logic t);
    case (s)
      0: return t ? 0 : 1;    1: return t ? 2 : 1;
      2: return t ? 9 : 3;    3: return t ? 5 : 4;
      4: return t ? 5 : 4;    5: return t ? 8 : 6;
      6: return t ? 7 : 6;    7: return t ? 8 : 4;
      8: return t ? 2 : 1;    9: return t ? 0 : 10;
      10: return t ? 12 : 11; 11: return t ? 12 : 11;
      12: return t ? 15 : 13; 13: return t ? 14 : 13;
      14: return t ? 15 : 11; default: return t ? 2 : 1;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_irs = 4'b0; m_ir = C_ID; m_byp = 1'b0; m_id = 32'b0;
    m_tdo = 1'b0; m_en = 1'b0;
  endtask

  task automatic tick(input logic t, input logic d);
    tms = t; tdi = d;
    @(posedge tck);
    case (m_st)
      10: m_irs = 4'b0001;
      11: m_irs = {d, m_irs[3:1]};
      3:  begin m_byp = 1'b0; m_id = IDV; end
      4:  begin m_byp = d; m_id = {d, m_id[31:1]}; end
      default: ;
    endcase
    m_st = nx(m_st, t);
    @(negedge tck);
    if (m_st == 15) m_ir = m_irs;
    if (m_st == 0)  m_ir = C_ID;
    m_en  = (m_st == 4) || (m_st == 11);
    m_tdo = (m_st == 11) ? m_irs[0] : (m_st == 4) ? ((m_ir == C_ID) ? m_id[0] : m_byp) : 1'b0;
    #1;
    chk("R2 R5 tdo_en", {31'b0, tdo_en}, {31'b0, m_en});
    chk("R4 R5 tdo", {31'b0, tdo}, {31'b0, m_tdo});
    chk("R10 port_owned", {31'b0, port_owned}, {31'b0, (m_ir == C_ID)});
  endtask

  task automatic to_idle();
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  task automatic scan_ir(input logic [3:0] code, output logic [3:0] cap);
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      cap[i] = tdo;
      tick(i == 3, code[i]);
    end
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tick(i == n - 1, din[i]);
    end
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [3:0]  cap;
    logic [31:0] dout;
    void'($urandom(32'd20240517));
    rst_n = 1'b0; tms = 1'b0; tdi = 1'b0;
    model_reset();
    repeat (4) @(posedge tck);
    @(negedge tck); #1;
    // R1: held in reset even with tms low
    chk("R1 reset tdo_en", {31'b0, tdo_en}, 32'd0);
    chk("R1 reset tdo", {31'b0, tdo}, 32'd0);
    chk("R1 reset port_owned", {31'b0, port_owned}, 32'd1);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);

    // R1 R8: identification selected after reset
    scan_dr(32, 32'h0, dout);
    chk("R1 R8 idcode after reset", dout, IDV);

    // R6: capture pattern; load bypass
    scan_ir(C_BYP, cap);
    chk("R6 capture pattern", {28'b0, cap}, 32'd1);
    chk("R10 bypass not owned", {31'b0, port_owned}, 32'd0);

    // R9: bypass delay
    scan_dr(8, 32'hB4, dout);
    chk("R9 bypass scan", dout, 32'h68);

    // R9 R10: undefined code acts as bypass
    scan_ir(4'b0101, cap);
    chk("R10 undefined not owned", {31'b0, port_owned}, 32'd0);
    scan_dr(6, 32'h2D, dout);
    chk("R9 undefined bypass", dout, 32'h1A);

    // R7: instruction takes effect at the Update-IR falling edge
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) tick(i == 3, C_ID[i]);
    chk("R7 not yet active in Exit1-IR", {31'b0, port_owned}, 32'd0);
    tick(1'b1, 1'b0);
    chk("R7 active after Update-IR", {31'b0, port_owned}, 32'd1);
    tick(1'b0, 1'b0);

    // R2: data scan interrupted by Pause-DR
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    dout = '0;
    for (int i = 0; i < 4; i++) begin dout[i] = tdo; tick(i == 3, 1'b0); end
    tick(1'b0, 1'b0); tick(1'b0, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0);
    for (int i = 4; i < 8; i++) begin dout[i] = tdo; tick(i == 7, 1'b0); end
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
    chk("R2 pause path data", {24'b0, dout[7:0]}, {24'b0, IDV[7:0]});

    // R3: five ones from random states
    for (int k = 0; k < 20; k++) begin
      to_idle();
      scan_ir(C_BYP, cap);
      for (int j = 0; j < int'($urandom % 12); j++) tick(1'($urandom % 2), 1'($urandom % 2));
      for (int j = 0; j < 5; j++) tick(1'b1, 1'b0);
      chk("R3 five ones restore idcode", {31'b0, port_owned}, 32'd1);
      chk("R3 five ones tdo_en", {31'b0, tdo_en}, 32'd0);
    end

    // R1: reset in the middle of a bypass shift
    to_idle();
    scan_ir(C_BYP, cap);
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    chk("R5 in Shift-DR", {31'b0, tdo_en}, 32'd1);
    rst_n = 1'b0;
    #1;
    chk("R1 async tdo_en", {31'b0, tdo_en}, 32'd0);
    chk("R1 async owned", {31'b0, port_owned}, 32'd1);
    model_reset();
    @(negedge tck); #1;
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0);

    // R2 R4 R5 R10: random walk against the model
    for (int i = 0; i < 4000; i++) tick(($urandom % 3) == 0, 1'($urandom % 2));

    done = 1;
    summary();
    $finish;
  end

endmodule